// File: doc/BRIEF.md
# Dual-Source Transmit Mode Controller

This block chooses, once per character slot, what 7-bit character goes to the line encoder of a serial uplink. Two sources compete for the slot. One is a tracking-data store, the SRAM side. The other is a slow-control buffer, the HDLC side. Each source offers a word with a valid flag. A 2-bit mode input picks one of three policies: SRAM only, HDLC only, or SRAM-first priority. In priority mode the HDLC side gets a slot only when it really holds data.

Every character leaves with a flag. The flag tells the encoder whether the character is data or a command character, which can never decode as data. The block opens each run of data from a source with a header command character that names that source. When no eligible source has data, it fills the slot with an idle command character. The block is paced by a character-rate enable. It consumes a source word by pulsing that source's read strobe during the enable cycle in which the word is taken. The word is presented on the output from the next clock edge.

Top module: `dstx_ctrl`

## Requirements
- R1: Reset is synchronous and active low. While `rst_n` is low both read strobes stay low. From the edge that samples reset low, the output is the idle character 7'h3C with `char_ctrl` = 1.
- R2: `char_out` and `char_ctrl` change only on clock edges where `char_en` is high. Read strobes are high only in cycles where `char_en` is high.
- R3: `mode_sel` = 2'b00 selects SRAM only, so `hdlc_rd` never rises. `mode_sel` = 2'b01 selects HDLC only, so `sram_rd` never rises.
- R4: `mode_sel` = 2'b10 and 2'b11 both select priority mode. A slot goes to SRAM whenever `sram_valid` is high, whatever the source of the current run. It goes to HDLC only when `sram_valid` is low and `hdlc_valid` is high.
- R5: A slot may go to a source that is not the source of the current run, or go to a source when there is no current run. That slot carries a header with `char_ctrl` = 1: 7'h1C for SRAM or 7'h5C for HDLC. No read strobe is given in that slot, and the run now belongs to that source.
- R6: A slot may go to the source that owns the current run. In that slot the source's read strobe is high for exactly that enable cycle. From the next edge `char_out` equals the word that was offered and `char_ctrl` = 0.
- R7: When no source is eligible under the mode, the slot carries the idle character 7'h3C with `char_ctrl` = 1 and ends the current run. The next data from either source is therefore preceded by a header.
- R8: `sram_rd` and `hdlc_rd` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| char_en | input | 1 | Character-slot enable |
| mode_sel | input | 2 | Policy: 00 SRAM only, 01 HDLC only, 1x priority |
| sram_word | input | 7 | Word offered by the tracking-data store |
| sram_valid | input | 1 | `sram_word` holds data |
| sram_rd | output | 1 | Consume the SRAM word this cycle |
| hdlc_word | input | 7 | Word offered by the slow-control buffer |
| hdlc_valid | input | 1 | `hdlc_word` holds data |
| hdlc_rd | output | 1 | Consume the HDLC word this cycle |
| char_out | output | 7 | Character to the encoder |
| char_ctrl | output | 1 | 1 = command character, 0 = data |

## Verification
The assertions assume that each source behaves like a show-ahead queue. A source keeps its valid flag and word steady until it sees its own read strobe at a clock edge, and only then moves on to the next word. They also assume that `mode_sel` is sampled only as a level on each cycle. The bench builds both sources as queues with exactly this behaviour. Each source pops only on the strobe and refills at random between slots. The bench changes mode, enable spacing and refill rates only at phase boundaries, on a falling edge. This covers empty sources, bursts and mid-stream mode changes without breaking the handshake.

// File: rtl/dstx_pkg.sv
package dstx_pkg;

    localparam int DSTX_CHAR_W = 7;

    typedef enum logic [1:0] {
        BLK_NONE = 2'd0,
        BLK_SRAM = 2'd1,
        BLK_HDLC = 2'd2
    } blk_e;

    typedef enum logic [1:0] {
        ACT_IDLE = 2'd0,
        ACT_HDR  = 2'd1,
        ACT_DATA = 2'd2
    } act_e;

    typedef enum logic [1:0] {
        MODE_SRAM_ONLY = 2'b00,
        MODE_HDLC_ONLY = 2'b01,
        MODE_PRIO      = 2'b10,
        MODE_PRIO_ALT  = 2'b11
    } mode_e;

endpackage

// File: rtl/dstx_policy.sv
module dstx_policy
    import dstx_pkg::*;
(
    input  logic [1:0] mode_sel,
    input  logic       sram_valid,
    input  logic       hdlc_valid,
    output blk_e       pick
);

    mode_e mode;
    assign mode = mode_e'(mode_sel);

    always_comb begin
        pick = BLK_NONE;
        case (mode)
            MODE_SRAM_ONLY: pick = sram_valid ? BLK_SRAM : BLK_NONE;
            MODE_HDLC_ONLY: pick = hdlc_valid ? BLK_HDLC : BLK_NONE;
            default: begin
                if (sram_valid)
                    pick = BLK_SRAM;
                else if (hdlc_valid)
                    pick = BLK_HDLC;
                else
                    pick = BLK_NONE;
            end
        endcase
    end

endmodule

// File: rtl/dstx_slot.sv
module dstx_slot
    import dstx_pkg::*;
(
    input  blk_e pick,
    input  blk_e cur_blk,
    output act_e act
);

    always_comb begin
        if (pick == BLK_NONE)
            act = ACT_IDLE;
        else if (pick == cur_blk)
            act = ACT_DATA;
        else
            act = ACT_HDR;
    end

endmodule

// File: rtl/dstx_char_sel.sv
module dstx_char_sel
    import dstx_pkg::*;
#(
    parameter int                CHAR_W    = DSTX_CHAR_W,
    parameter logic [CHAR_W-1:0] IDLE_CODE = 7'h3C,
    parameter logic [CHAR_W-1:0] SRAM_HDR  = 7'h1C,
    parameter logic [CHAR_W-1:0] HDLC_HDR  = 7'h5C
) (
    input  act_e              act,
    input  blk_e              pick,
    input  logic [CHAR_W-1:0] sram_word,
    input  logic [CHAR_W-1:0] hdlc_word,
    output logic [CHAR_W-1:0] chr,
    output logic              ctrl
);

    always_comb begin
        chr  = IDLE_CODE;
        ctrl = 1'b1;
        case (act)
            ACT_HDR: begin
                chr  = (pick == BLK_SRAM) ? SRAM_HDR : HDLC_HDR;
                ctrl = 1'b1;
            end
            ACT_DATA: begin
                chr  = (pick == BLK_SRAM) ? sram_word : hdlc_word;
                ctrl = 1'b0;
            end
            default: begin
                chr  = IDLE_CODE;
                ctrl = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/dstx_ctrl.sv
module dstx_ctrl
    import dstx_pkg::*;
#(
    parameter int                CHAR_W    = DSTX_CHAR_W,
    parameter logic [CHAR_W-1:0] IDLE_CODE = 7'h3C,
    parameter logic [CHAR_W-1:0] SRAM_HDR  = 7'h1C,
    parameter logic [CHAR_W-1:0] HDLC_HDR  = 7'h5C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_en,
    input  logic [1:0]        mode_sel,
    input  logic [CHAR_W-1:0] sram_word,
    input  logic              sram_valid,
    output logic              sram_rd,
    input  logic [CHAR_W-1:0] hdlc_word,
    input  logic              hdlc_valid,
    output logic              hdlc_rd,
    output logic [CHAR_W-1:0] char_out,
    output logic              char_ctrl
);

    typedef struct packed {
        blk_e              blk;
        logic [CHAR_W-1:0] chr;
        logic              ctrl;
    } regs_t;

    regs_t regs_d, regs_q;

    blk_e              pick;
    act_e              act;
    logic [CHAR_W-1:0] sel_chr;
    logic              sel_ctrl;

    dstx_policy u_policy (
        .mode_sel   (mode_sel),
        .sram_valid (sram_valid),
        .hdlc_valid (hdlc_valid),
        .pick       (pick)
    );

    dstx_slot u_slot (
        .pick    (pick),
        .cur_blk (regs_q.blk),
        .act     (act)
    );

    dstx_char_sel #(
        .CHAR_W    (CHAR_W),
        .IDLE_CODE (IDLE_CODE),
        .SRAM_HDR  (SRAM_HDR),
        .HDLC_HDR  (HDLC_HDR)
    ) u_char_sel (
        .act       (act),
        .pick      (pick),
        .sram_word (sram_word),
        .hdlc_word (hdlc_word),
        .chr       (sel_chr),
        .ctrl      (sel_ctrl)
    );

    always_comb begin
        regs_d  = regs_q;
        sram_rd = 1'b0;
        hdlc_rd = 1'b0;
        if (!rst_n) begin
            regs_d.blk  = BLK_NONE;
            regs_d.chr  = IDLE_CODE;
            regs_d.ctrl = 1'b1;
        end else if (char_en) begin
            regs_d.chr  = sel_chr;
            regs_d.ctrl = sel_ctrl;
            regs_d.blk  = (act == ACT_IDLE) ? BLK_NONE : pick;
            if (act == ACT_DATA) begin
                sram_rd = (pick == BLK_SRAM);
                hdlc_rd = (pick == BLK_HDLC);
            end
        end
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign char_out  = regs_q.chr;
    assign char_ctrl = regs_q.ctrl;

    AST_RST_NO_RD: assert property (@(posedge clk)
        !rst_n |-> (!sram_rd && !hdlc_rd)); // R1

    AST_HOLD_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !char_en) |=> ($stable(char_out) && $stable(char_ctrl))); // R2

    AST_RD_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_rd || hdlc_rd) |-> char_en); // R2

    AST_SRAM_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b00) |-> !hdlc_rd); // R3

    AST_HDLC_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b01) |-> !sram_rd); // R3

    AST_PRIO_SRAM_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel[1] && sram_valid) |-> !hdlc_rd); // R4

    AST_SRAM_RD_AFTER_HDR: assert property (@(posedge clk) disable iff (!rst_n)
        sram_rd |-> (!char_ctrl || char_out == SRAM_HDR)); // R5

    AST_HDLC_RD_AFTER_HDR: assert property (@(posedge clk) disable iff (!rst_n)
        hdlc_rd |-> (!char_ctrl || char_out == HDLC_HDR)); // R5

    AST_SRAM_DATA_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_rd && sram_valid) |=> (!char_ctrl && char_out == $past(sram_word))); // R6

    AST_HDLC_DATA_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (hdlc_rd && hdlc_valid) |=> (!char_ctrl && char_out == $past(hdlc_word))); // R6

    AST_RD_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_rd |-> sram_valid) and (hdlc_rd |-> hdlc_valid)); // R6

    AST_IDLE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (char_en && !sram_valid && !hdlc_valid) |=> (char_ctrl && char_out == IDLE_CODE)); // R7

    AST_RD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sram_rd, hdlc_rd})); // R8

endmodule

// File: tb/dstx_ctrl_tb.sv
`timescale 1ns/1ps
module dstx_ctrl_tb_top;

    localparam logic [6:0] IDLE_C = 7'h3C;
    localparam logic [6:0] HDR_S  = 7'h1C;
    localparam logic [6:0] HDR_H  = 7'h5C;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       char_en = 1'b0;
    logic [1:0] mode_sel = 2'b10;
    logic [6:0] sram_word = '0;
    logic       sram_valid = 1'b0;
    logic       sram_rd;
    logic [6:0] hdlc_word = '0;
    logic       hdlc_valid = 1'b0;
    logic       hdlc_rd;
    logic [6:0] char_out;
    logic       char_ctrl;

    always #10 clk = ~clk;

    dstx_ctrl dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .char_en    (char_en),
        .mode_sel   (mode_sel),
        .sram_word  (sram_word),
        .sram_valid (sram_valid),
        .sram_rd    (sram_rd),
        .hdlc_word  (hdlc_word),
        .hdlc_valid (hdlc_valid),
        .hdlc_rd    (hdlc_rd),
        .char_out   (char_out),
        .char_ctrl  (char_ctrl)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [6:0] sq[$];
    logic [6:0] hq[$];

    // model state: 0 no run, 1 SRAM run, 2 HDLC run
    int         m_blk  = 0;
    logic [6:0] m_chr  = IDLE_C;
    logic       m_ctrl = 1'b1;
    string      m_tag  = "R1";
    int         cyc    = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act_v, input int exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act_v, exp_v);
        end
    endtask

    task automatic run(input int n, input bit rst_v, input logic [1:0] md,
                       input int ps, input int ph, input int div);
        for (int i = 0; i < n; i++) begin
            int  pick;
            bit  es, eh;
            bit  xs, xh;
            @(negedge clk);
            chk(char_out == m_chr, m_tag, "char_out", char_out, m_chr);
            chk(char_ctrl == m_ctrl, m_tag, "char_ctrl", char_ctrl, m_ctrl);
            if (sq.size() < 6 && $urandom_range(99) < ps) sq.push_back(7'($urandom));
            if (hq.size() < 6 && $urandom_range(99) < ph) hq.push_back(7'($urandom));
            rst_n      = rst_v;
            mode_sel   = md;
            char_en    = ((cyc % div) == 0);
            sram_valid = (sq.size() > 0);
            sram_word  = (sq.size() > 0) ? sq[0] : 7'h00;
            hdlc_valid = (hq.size() > 0);
            hdlc_word  = (hq.size() > 0) ? hq[0] : 7'h00;
            cyc++;
            #1;
            es = sram_valid && (md != 2'b01);
            eh = hdlc_valid && (md != 2'b00);
            pick = es ? 1 : (eh ? 2 : 0);
            xs = 0;
            xh = 0;
            if (!rst_v) begin
                m_blk = 0; m_chr = IDLE_C; m_ctrl = 1; m_tag = "R1";
            end else if (!char_en) begin
                m_tag = "R2";
            end else if (pick == 0) begin
                m_blk = 0; m_chr = IDLE_C; m_ctrl = 1; m_tag = "R7";
            end else if (pick != m_blk) begin
                m_blk = pick; m_chr = (pick == 1) ? HDR_S : HDR_H; m_ctrl = 1; m_tag = "R5";
            end else begin
                m_ctrl = 0; m_tag = "R6";
                if (pick == 1) begin m_chr = sq.pop_front(); xs = 1; end
                else begin m_chr = hq.pop_front(); xh = 1; end
            end
            chk(sram_rd == xs, md[1] ? "R4" : "R3", "sram_rd", sram_rd, xs);
            chk(hdlc_rd == xh, md[1] ? "R4" : "R3", "hdlc_rd", hdlc_rd, xh);
            chk(!(sram_rd && hdlc_rd), "R8", "both strobes", {sram_rd, hdlc_rd}, 0);
        end
    endtask

    initial begin
        run(4,   0, 2'b10, 50, 50, 1);   // R1 reset state
        run(300, 1, 2'b10, 60, 40, 1);   // R4 priority, mixed
        run(60,  1, 2'b10, 0,  0,  1);   // R7 drain to idle
        run(80,  1, 2'b10, 0,  35, 1);   // R4 HDLC fallback only
        run(200, 1, 2'b00, 50, 80, 1);   // R3 SRAM only
        run(200, 1, 2'b01, 70, 50, 4);   // R3 HDLC only, sparse slots, R2
        run(300, 1, 2'b11, 20, 20, 2);   // R4 alternate priority code
        run(3,   0, 2'b11, 50, 50, 1);   // R1 mid-run reset
        run(200, 1, 2'b10, 90, 90, 1);   // R5/R6 long runs
        run(150, 1, 2'b10, 10, 90, 3);   // R5 frequent source switches
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule